// File: doc/BRIEF.md
# Linked Page-Table Address Translator

This block turns linear input addresses, as produced by a trace-buffer writer, into physical addresses. Memory is described by a ring of 4KB translation tables. In each table, the first 256 entries point to 4KB data pages, which covers 1MB of input space. The last two entries link to the neighbouring tables: entry 511 points to the next table and entry 510 to the previous one. Each entry is 64 bits. Bits 63..12 hold a page-aligned address, bit 0 is the valid flag, and the bits in between are zero.

The block remembers which table it last used. It holds that table's page address and its table number, counted from the first table. A lookup in the same table costs one memory read. A lookup in another table first follows the link entries, one read per hop, forward or backward, and then reads the data-page entry. In pass-through mode, addresses go out unchanged and no memory is read. Requests are handled one at a time. The configuration port sets enable, mode and the two base addresses, and a ready status shows when the unit is idle.

Top module: `link_xlate`

## Requirements
- R1: After reset, `stat_ready` is 1 and `req_ready`, `resp_valid` and `mem_req_valid` are 0.
- R2: Configuration writes use `cfg_sel` codes 0 = control (bit 0 enables), 1 = mode (bit 0: 1 translate, 0 pass-through), 2 = table base (address bits 11..0 ignored) and 3 = input base (bits 19..0 ignored). `req_ready` is 1 only while the unit is enabled and idle, so no request is taken while it is disabled.
- R3: In pass-through mode, an accepted request gives `resp_valid` in the cycle after acceptance. `resp_addr` equals the request address, `resp_fault` is 0, and no memory read is made.
- R4: In translate mode, let offset = input address minus input base, table number = offset bits 31..20 and index = offset bits 19..12. When the table number equals the remembered one, exactly one read is made, at remembered page address + index*8. The result is entry bits 39..12 joined with input bits 11..0. A memory request holds its address until `mem_req_ready`.
- R5: A data-page entry whose bit 0 is clear gives a response with `resp_fault` = 1 and `resp_addr` = 0.
- R6: A table number above the remembered one is reached by reading entry 511 (byte offset 0xFF8) of the current table once per hop. Each hop adopts the linked page and adds one to the remembered number. The data-page entry is then read.
- R7: A table number below the remembered one is reached the same way, through entry 510 (byte offset 0xFF0), subtracting one per hop.
- R8: A link entry whose bit 0 is clear ends the walk with a fault response (address 0) and leaves the remembered table unchanged.
- R9: The remembered table persists across requests, so a later request in that table needs only one read.
- R10: `stat_ready` is 0 from the cycle after a request is accepted until the response has been given, and it returns to 1 afterwards.
- R11: While enabled, writes to the mode, table base and input base registers are ignored.
- R12: A write that sets enable while the unit is disabled resets the remembered table to table number 0 at the table base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 mode, 2 table base, 3 input base |
| cfg_wdata | input | AW | Configuration write data |
| stat_ready | output | 1 | Idle and safe to reconfigure |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_addr | input | AW | Input address |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_addr | output | AW | Translated address, 0 on fault |
| resp_fault | output | 1 | Translation fault |
| mem_req_valid | output | 1 | 64-bit memory read request |
| mem_req_addr | output | AW | Byte address of the entry to read |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read data |

## Verification
The assertions assume that the memory returns exactly one response for each accepted read, and only while a read is in flight. They also assume that mode and control are not changed in the middle of a walk. The bench's memory model answers every read one cycle after accepting it, and the bench changes configuration only between transactions. The bench requests only table numbers that exist in its three-table ring. The one exception is the broken-link case, where the missing link itself makes the walk end.

// File: rtl/link_xlate.sv
module link_xlate #(
  parameter int AW  = 40,
  parameter int TNW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          stat_ready,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          resp_valid,
  output logic [AW-1:0] resp_addr,
  output logic          resp_fault,
  output logic          mem_req_valid,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [63:0]   mem_rsp_data
);
  localparam int PW = AW - 12;
  localparam int MW = AW - 20;
  localparam logic [1:0] SEL_CTRL = 2'd0, SEL_MODE = 2'd1, SEL_TBASE = 2'd2, SEL_IBASE = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} st_t;
  st_t st;

  logic          en_r, xl_r;
  logic [PW-1:0] tbase_r, cur_pg;
  logic [MW-1:0] ibase_r;
  logic [TNW-1:0] cur_tn;
  logic [AW-1:0] rq_addr;
  logic          is_link, go_fwd;

  logic [AW-1:0]  off;
  logic [TNW-1:0] tgt;
  logic           need_fwd, need_back;
  logic [8:0]     eidx;

  assign off       = rq_addr - {ibase_r, 20'b0};
  assign tgt       = off[20+TNW-1:20];
  assign need_fwd  = tgt > cur_tn;
  assign need_back = tgt < cur_tn;
  assign eidx      = need_fwd ? 9'd511 : (need_back ? 9'd510 : {1'b0, off[19:12]});

  assign stat_ready    = (st == S_IDLE);
  assign req_ready     = en_r && (st == S_IDLE);
  assign mem_req_valid = (st == S_ISSUE);
  assign mem_req_addr  = {cur_pg, eidx, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r <= 1'b0; xl_r <= 1'b0;
      tbase_r <= '0; ibase_r <= '0;
      cur_pg <= '0; cur_tn <= '0;
    end else begin
      if (cfg_wr) begin
        case (cfg_sel)
          SEL_CTRL: begin
            en_r <= cfg_wdata[0];
            if (cfg_wdata[0] && !en_r) begin
              cur_pg <= tbase_r;
              cur_tn <= '0;
            end
          end
          SEL_MODE:  if (!en_r) xl_r <= cfg_wdata[0];
          SEL_TBASE: if (!en_r) tbase_r <= cfg_wdata[AW-1:12];
          SEL_IBASE: if (!en_r) ibase_r <= cfg_wdata[AW-1:20];
          default: ;
        endcase
      end
      if (st == S_WAIT && mem_rsp_valid && is_link && mem_rsp_data[0]) begin
        cur_pg <= mem_rsp_data[AW-1:12];
        cur_tn <= go_fwd ? cur_tn + 1'b1 : cur_tn - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      rq_addr <= '0;
      is_link <= 1'b0; go_fwd <= 1'b0;
      resp_valid <= 1'b0; resp_addr <= '0; resp_fault <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid && req_ready) begin
          rq_addr <= req_addr;
          if (xl_r) st <= S_ISSUE;
          else begin
            resp_valid <= 1'b1; resp_addr <= req_addr; resp_fault <= 1'b0;
            st <= S_DONE;
          end
        end
        S_ISSUE: if (mem_req_ready) begin
          is_link <= need_fwd | need_back;
          go_fwd  <= need_fwd;
          st      <= S_WAIT;
        end
        S_WAIT: if (mem_rsp_valid) begin
          if (is_link && mem_rsp_data[0]) st <= S_ISSUE;
          else begin
            resp_valid <= 1'b1;
            resp_fault <= !mem_rsp_data[0];
            resp_addr  <= mem_rsp_data[0] ? {mem_rsp_data[AW-1:12], rq_addr[11:0]} : '0;
            st         <= S_DONE;
          end
        end
        S_DONE: begin
          resp_valid <= 1'b0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_pass_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !xl_r) |=> (resp_valid && !resp_fault && resp_addr == $past(req_addr)));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !stat_ready);

  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_fault) |-> (resp_addr == '0));

  assert_low_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_fault) |-> (resp_addr[11:0] == rq_addr[11:0]));

  assert_base_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en_r && cfg_wr && cfg_sel == SEL_TBASE) |=> $stable(tbase_r));
endmodule

// File: tb/test_link_xlate.sv
module test_link_xlate;
  localparam int AW = 40;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic stat_ready, req_ready, resp_valid, resp_fault, mem_req_valid;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0, resp_addr, mem_req_addr;
  logic mem_req_ready;
  logic mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  int errors = 0, checks = 0;
  int nrd = 0;
  logic [AW-1:0] rd_log [0:15];
  logic break_link = 1'b0;

  localparam logic [AW-1:0] INB = 40'h10_0000;

  always #10 clk = ~clk;
  assign mem_req_ready = 1'b1;

  link_xlate #(.AW(AW), .TNW(12)) i_link_xlate (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .stat_ready(stat_ready), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .resp_valid(resp_valid), .resp_addr(resp_addr), .resp_fault(resp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  function automatic logic [AW-1:0] tbl(int k);
    return 40'h20_0000 + 40'(k) * 40'h3000;
  endfunction

  function automatic logic [AW-1:0] page(int t, int e);
    return 40'h8000_0000 + (40'(t * 256 + e) << 12);
  endfunction

  function automatic logic [63:0] mem_read(logic [AW-1:0] a);
    logic [63:0] d;
    d = '0;
    for (int k = 0; k < 3; k++) begin
      if (a[AW-1:12] == tbl(k)>>12) begin
        int e;
        e = int'(a[11:3]);
        if (e < 256) d = (k == 1 && e == 5) ? 64'h0 : {24'h0, page(k, e)} | 64'h1;
        else if (e == 510) d = {24'h0, tbl((k + 2) % 3)} | 64'h1;
        else if (e == 511) d = (k == 2 && break_link) ? 64'h0 : ({24'h0, tbl((k + 1) % 3)} | 64'h1);
      end
    end
    return d;
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem_read(mem_req_addr);
    if (mem_req_valid && mem_req_ready) begin
      rd_log[nrd % 16] <= mem_req_addr;
      nrd <= nrd + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [AW-1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  logic [AW-1:0] g_addr;
  logic g_fault;
  int g_reads, g_start;
  logic g_busy_seen;

  task automatic xact(input logic [AW-1:0] a);
    int n;
    @(negedge clk);
    g_start = nrd;
    req_valid = 1'b1; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    g_busy_seen = !stat_ready;
    n = 0;
    while (!resp_valid && n < 100) begin @(negedge clk); n++; end
    g_addr = resp_addr; g_fault = resp_fault; g_reads = nrd - g_start;
    @(negedge clk);
  endtask

  function automatic logic [AW-1:0] in_addr(int t, int e, int l);
    return INB + (40'(t) << 20) + (40'(e) << 12) + 40'(l);
  endfunction

  task automatic t_reset;
    chk(stat_ready === 1'b1, "R1 ready", 64'(stat_ready), 64'h1);
    chk(req_ready === 1'b0 && resp_valid === 1'b0 && mem_req_valid === 1'b0, "R1 idle outputs",
        {61'h0, req_ready, resp_valid, mem_req_valid}, 64'h0);
    req_valid = 1'b1; req_addr = 40'h1234;
    repeat (4) @(negedge clk);
    chk(req_ready === 1'b0 && resp_valid === 1'b0, "R2 disabled rejects", 64'(req_ready), 64'h0);
    req_valid = 1'b0;
  endtask

  task automatic t_pass;
    cfg(2'd1, 40'h0);
    cfg(2'd0, 40'h1);
    xact(40'h12_3456_789A);
    chk(g_addr == 40'h12_3456_789A && !g_fault, "R3 pass addr", 64'(g_addr), 64'h12_3456_789A);
    chk(g_reads == 0, "R3 pass no reads", 64'(g_reads), 64'h0);
    xact(40'h00_0000_0FFF);
    chk(g_addr == 40'hFFF && g_reads == 0, "R3 pass second", 64'(g_addr), 64'hFFF);
    chk(stat_ready === 1'b1, "R10 ready after pass", 64'(stat_ready), 64'h1);
    cfg(2'd0, 40'h0);
  endtask

  task automatic t_same;
    cfg(2'd1, 40'h1);
    cfg(2'd2, tbl(0) | 40'hABC);
    cfg(2'd3, INB | 40'h5_5555);
    cfg(2'd0, 40'h1);
    xact(in_addr(0, 3, 12'h123));
    chk(g_addr == (page(0, 3) | 40'h123) && !g_fault, "R4 same table addr", 64'(g_addr), 64'(page(0, 3) | 40'h123));
    chk(g_reads == 1 && rd_log[g_start % 16] == tbl(0) + 40'h18, "R4 entry read address",
        64'(rd_log[g_start % 16]), 64'(tbl(0) + 40'h18));
    chk(g_busy_seen, "R10 busy during walk", 64'(g_busy_seen), 64'h1);
    xact(in_addr(0, 255, 12'hFFF));
    chk(g_addr == (page(0, 255) | 40'hFFF) && g_reads == 1, "R9 last entry one read", 64'(g_addr), 64'(page(0, 255) | 40'hFFF));
  endtask

  task automatic t_fwd;
    xact(in_addr(2, 0, 12'h010));
    chk(g_addr == (page(2, 0) | 40'h10), "R6 forward addr", 64'(g_addr), 64'(page(2, 0) | 40'h10));
    chk(g_reads == 3, "R6 hop reads", 64'(g_reads), 64'h3);
    chk(rd_log[g_start % 16] == tbl(0) + 40'hFF8 && rd_log[(g_start + 1) % 16] == tbl(1) + 40'hFF8
        && rd_log[(g_start + 2) % 16] == tbl(2), "R6 link sequence",
        64'(rd_log[(g_start + 1) % 16]), 64'(tbl(1) + 40'hFF8));
    xact(in_addr(2, 4, 0));
    chk(g_reads == 1 && g_addr == page(2, 4), "R9 cached after hop", 64'(g_reads), 64'h1);
  endtask

  task automatic t_back;
    xact(in_addr(1, 7, 12'h008));
    chk(g_addr == (page(1, 7) | 40'h8), "R7 backward addr", 64'(g_addr), 64'(page(1, 7) | 40'h8));
    chk(g_reads == 2 && rd_log[g_start % 16] == tbl(2) + 40'hFF0 && rd_log[(g_start + 1) % 16] == tbl(1) + 40'h38,
        "R7 prev link read", 64'(rd_log[g_start % 16]), 64'(tbl(2) + 40'hFF0));
  endtask

  task automatic t_invalid;
    xact(in_addr(1, 5, 12'h444));
    chk(g_fault && g_addr == 40'h0, "R5 invalid entry fault", 64'(g_addr), 64'h0);
    chk(g_reads == 1, "R5 single read", 64'(g_reads), 64'h1);
  endtask

  task automatic t_locked;
    cfg(2'd2, tbl(2));
    cfg(2'd3, 40'h700_0000);
    cfg(2'd1, 40'h0);
    xact(in_addr(1, 9, 12'h00C));
    chk(g_addr == (page(1, 9) | 40'hC) && g_reads == 1, "R11 writes ignored while enabled",
        64'(g_addr), 64'(page(1, 9) | 40'hC));
  endtask

  task automatic t_badlink;
    xact(in_addr(2, 1, 0));
    chk(g_addr == page(2, 1) && g_reads == 2, "R6 forward one hop", 64'(g_addr), 64'(page(2, 1)));
    break_link = 1'b1;
    xact(in_addr(3, 0, 0));
    chk(g_fault && g_addr == 40'h0 && g_reads == 1, "R8 broken link fault", 64'(g_addr), 64'h0);
    xact(in_addr(2, 2, 12'h002));
    chk(g_addr == (page(2, 2) | 40'h2) && g_reads == 1, "R8 cache unchanged", 64'(g_reads), 64'h1);
    break_link = 1'b0;
  endtask

  task automatic t_reenable;
    cfg(2'd0, 40'h0);
    cfg(2'd0, 40'h1);
    xact(in_addr(0, 1, 12'h0F0));
    chk(g_addr == (page(0, 1) | 40'hF0) && g_reads == 1 && rd_log[g_start % 16] == tbl(0) + 40'h8,
        "R12 enable resets cache", 64'(rd_log[g_start % 16]), 64'(tbl(0) + 40'h8));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_pass;
    t_same;
    t_fwd;
    t_back;
    t_invalid;
    t_locked;
    t_badlink;
    t_reenable;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule